// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small 16-bit processor built around a single accumulator. Every instruction names one operation and one memory address; the accumulator supplies the other operand and receives the result, so arithmetic takes the form AC <= AC op Mem[addr]. A control state machine with registered outputs walks each instruction through an initialise step (once after reset), a fetch, a decode and an execute sequence. Each execute sequence depends on the instruction class: memory-operand arithmetic, store, accumulator-only arithmetic, taken branch or skipped branch.

The core drives one synchronous memory port that holds both program and data. A read returns its word one clock after the read strobe, so the fetch and every memory-operand step spend one extra cycle waiting. A HALT instruction parks the machine and raises a halted output. The surrounding logic can then inspect the accumulator, the flags and memory.

Top module: `acc_cpu`

## Requirements
- R1: While the synchronous reset `rst` is high, `acc_value` is 0, `flag_zero` and `flag_neg` are 0, `halted` is 0 and neither memory strobe is set. After release, one initialise cycle with no strobe follows, and then the first fetch drives `mem_rd`=1 with `mem_addr`=0. In every fetch cycle `mem_addr` equals the program counter.
- R2: An instruction word holds the opcode in bits 15:12 and the operand/target address in bits 11:0. The opcodes are 0 LOAD, 1 STORE, 2 ADD, 3 SUB, 4 INC, 5 DEC, 6 SHL, 7 ROR, 8 BR, 9 BRZ, A BRN and F HALT.
- R3: LOAD sets AC to Mem[a]. ADD sets AC to AC+Mem[a] and SUB sets AC to AC-Mem[a], both modulo 2^16. Each takes 5 cycles.
- R4: STORE drives exactly one write cycle, with `mem_wr`=1, `mem_addr`=a and `mem_wdata`=AC. The accumulator is unchanged. STORE takes 4 cycles.
- R5: INC and DEC add or subtract 1 modulo 2^16. SHL shifts AC left by one and fills bit 0 with 0. ROR rotates AC right by one, moving bit 0 into bit 15. Each takes 4 cycles and makes no memory access outside its fetch.
- R6: After every accumulator write, `flag_zero` is (AC==0) and `flag_neg` is AC bit 15. STORE, branches and no-operations leave both flags unchanged.
- R7: BR always branches, BRZ branches when `flag_zero` is 1, and BRN branches when `flag_neg` is 1. A taken branch makes the next fetch use the address field. A branch that is not taken continues at PC+1. Every branch takes 4 cycles.
- R8: Opcodes B, C, D and E are no-operations. Each takes 3 cycles, writes no memory and leaves AC and the flags unchanged.
- R9: HALT takes 3 cycles, after which `halted` is 1 and stays 1 until reset. While halted there are no memory strobes and AC is stable.
- R10: Read data is consumed in the cycle after the cycle in which `mem_rd` was set. `mem_rd` and `mem_wr` are never 1 in the same cycle.

Cycle counts are measured in clocks from the start of an instruction's fetch. The initialise cycle adds one clock at the start of a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read strobe; data returns one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rdata | input | 16 | Read data from memory |
| acc_value | output | 16 | Accumulator contents |
| flag_zero | output | 1 | Registered zero flag |
| flag_neg | output | 1 | Registered negative flag |
| halted | output | 1 | Core has executed HALT |

## Verification
The assertions watch properties that must hold on every cycle. The read and write strobes never overlap, and each fetch addresses the program counter. The flags follow the accumulator after each write and hold otherwise. A skipped branch advances the PC by one and a taken branch loads the target. A store leaves the accumulator alone, and the halted state stays silent and stable. The correct arithmetic results, the per-class cycle counts, the fact that only branches which should branch do so, and the harmlessness of the no-operation opcodes can only be shown by the bench's directed programs. The bench checks these through the final accumulator, the flags, memory contents and the total run length.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 4'h0,
        OP_STORE = 4'h1,
        OP_ADD   = 4'h2,
        OP_SUB   = 4'h3,
        OP_INC   = 4'h4,
        OP_DEC   = 4'h5,
        OP_SHL   = 4'h6,
        OP_ROR   = 4'h7,
        OP_BR    = 4'h8,
        OP_BRZ   = 4'h9,
        OP_BRN   = 4'hA,
        OP_HALT  = 4'hF
    } opcode_e;

    typedef enum logic [3:0] {
        S_INIT,
        S_FETCH,
        S_FWAIT,
        S_DECODE,
        S_MREAD,
        S_MWAIT,
        S_MWRITE,
        S_ACCOP,
        S_BR_TAKE,
        S_BR_SKIP,
        S_HALTED
    } state_e;

    typedef enum logic [2:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB,
        ALU_INC,
        ALU_DEC,
        ALU_SHL,
        ALU_ROR
    } alu_op_e;

    typedef enum logic [2:0] {
        CL_MEMALU,
        CL_STORE,
        CL_UNARY,
        CL_BRANCH,
        CL_HALT,
        CL_NOP
    } iclass_e;

    typedef struct packed {
        logic    clr;
        logic    mem_rd;
        logic    mem_wr;
        logic    addr_ir;
        logic    ir_ld;
        logic    pc_inc;
        logic    pc_ld;
        logic    acc_ld;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic iclass_e classify(input logic [OPC_W-1:0] opc);
        iclass_e c;
        case (opc)
            OP_LOAD, OP_ADD, OP_SUB:         c = CL_MEMALU;
            OP_STORE:                        c = CL_STORE;
            OP_INC, OP_DEC, OP_SHL, OP_ROR:  c = CL_UNARY;
            OP_BR, OP_BRZ, OP_BRN:           c = CL_BRANCH;
            OP_HALT:                         c = CL_HALT;
            default:                         c = CL_NOP;
        endcase
        return c;
    endfunction

    function automatic alu_op_e alu_select(input logic [OPC_W-1:0] opc);
        alu_op_e o;
        case (opc)
            OP_ADD:  o = ALU_ADD;
            OP_SUB:  o = ALU_SUB;
            OP_INC:  o = ALU_INC;
            OP_DEC:  o = ALU_DEC;
            OP_SHL:  o = ALU_SHL;
            OP_ROR:  o = ALU_ROR;
            default: o = ALU_PASS;
        endcase
        return o;
    endfunction

    function automatic logic branch_taken(input logic [OPC_W-1:0] opc,
                                          input logic z, input logic n);
        logic t;
        case (opc)
            OP_BR:   t = 1'b1;
            OP_BRZ:  t = z;
            OP_BRN:  t = n;
            default: t = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero,
    output logic         neg
);

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_INC: y = a + W'(1);
            ALU_DEC: y = a - W'(1);
            ALU_SHL: y = {a[W-2:0], 1'b0};
            ALU_ROR: y = {a[0], a[W-1:1]};
            default: y = b;
        endcase
    end

    assign zero = (y == '0);
    assign neg  = y[W-1];

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] ir_opc,
    input  logic             flag_z,
    input  logic             flag_n,
    output ctrl_t            ctl,
    output state_e           state_q,
    output logic             halted
);

    state_e  state_d;
    iclass_e cls;

    assign cls = classify(ir_opc);

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_INIT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            S_INIT:   state_d = S_FETCH;
            S_FETCH:  state_d = S_FWAIT;
            S_FWAIT:  state_d = S_DECODE;
            S_DECODE: begin
                case (cls)
                    CL_MEMALU: state_d = S_MREAD;
                    CL_STORE:  state_d = S_MWRITE;
                    CL_UNARY:  state_d = S_ACCOP;
                    CL_BRANCH: state_d = branch_taken(ir_opc, flag_z, flag_n)
                                         ? S_BR_TAKE : S_BR_SKIP;
                    CL_HALT:   state_d = S_HALTED;
                    default:   state_d = S_FETCH;
                endcase
            end
            S_MREAD:   state_d = S_MWAIT;
            S_MWAIT,
            S_MWRITE,
            S_ACCOP,
            S_BR_TAKE,
            S_BR_SKIP: state_d = S_FETCH;
            S_HALTED:  state_d = S_HALTED;
            default:   state_d = S_INIT;
        endcase
    end

    // Outputs come from the state register (plus the instruction register
    // in decode/execute), never from memory data, so no loop is formed.
    always_comb begin
        ctl = '0;
        case (state_q)
            S_INIT:    ctl.clr    = 1'b1;
            S_FETCH:   ctl.mem_rd = 1'b1;
            S_FWAIT:   ctl.ir_ld  = 1'b1;
            S_DECODE:  ctl.pc_inc = (cls != CL_BRANCH);
            S_MREAD: begin
                ctl.mem_rd  = 1'b1;
                ctl.addr_ir = 1'b1;
            end
            S_MWAIT: begin
                ctl.acc_ld = 1'b1;
                ctl.alu_op = alu_select(ir_opc);
            end
            S_MWRITE: begin
                ctl.mem_wr  = 1'b1;
                ctl.addr_ir = 1'b1;
            end
            S_ACCOP: begin
                ctl.acc_ld = 1'b1;
                ctl.alu_op = alu_select(ir_opc);
            end
            S_BR_TAKE: ctl.pc_ld  = 1'b1;
            S_BR_SKIP: ctl.pc_inc = 1'b1;
            default:   ctl = '0;
        endcase
    end

    assign halted = (state_q == S_HALTED);

    AST_HALT_LOCK: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_HALTED) |=> (state_q == S_HALTED)); // R9

    AST_INIT_ONCE: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_INIT) |=> (state_q == S_FETCH)); // R1

endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int DATA_W = ADDR_W + OPC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [OPC_W-1:0]  ir_opc,
    output logic [ADDR_W-1:0] ir_addr,
    output logic [ADDR_W-1:0] pc_q,
    output logic [DATA_W-1:0] acc_q,
    output logic              z_q,
    output logic              n_q
);

    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] alu_y;
    logic              alu_z;
    logic              alu_n;

    assign ir_opc  = ir_q[DATA_W-1 -: OPC_W];
    assign ir_addr = ir_q[ADDR_W-1:0];

    acc_cpu_alu #(.W(DATA_W)) u_alu (
        .a    (acc_q),
        .b    (mem_rdata),
        .op   (ctl.alu_op),
        .y    (alu_y),
        .zero (alu_z),
        .neg  (alu_n)
    );

    always_ff @(posedge clk) begin
        if (rst || ctl.clr)  pc_q <= '0;
        else if (ctl.pc_ld)  pc_q <= ir_addr;
        else if (ctl.pc_inc) pc_q <= pc_q + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)            ir_q <= '0;
        else if (ctl.ir_ld) ir_q <= mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            acc_q <= '0;
            z_q   <= 1'b0;
            n_q   <= 1'b0;
        end else if (ctl.acc_ld) begin
            acc_q <= alu_y;
            z_q   <= alu_z;
            n_q   <= alu_n;
        end
    end

    assign mem_addr  = ctl.addr_ir ? ir_addr : pc_q;
    assign mem_wdata = acc_q;

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.acc_ld && !ctl.clr) |=> $stable({z_q, n_q})); // R6

    AST_FLAG_TRACK: assert property (@(posedge clk) disable iff (rst)
        ctl.acc_ld |=> ((z_q == (acc_q == '0)) && (n_q == acc_q[DATA_W-1]))); // R6

    AST_STORE_KEEP: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_wr |=> $stable(acc_q)); // R4

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int DATA_W = ADDR_W + OPC_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc_value,
    output logic              flag_zero,
    output logic              flag_neg,
    output logic              halted
);

    ctrl_t             ctl;
    state_e            state_q;
    logic [OPC_W-1:0]  ir_opc;
    logic [ADDR_W-1:0] ir_addr;
    logic [ADDR_W-1:0] pc_q;

    acc_cpu_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ir_opc  (ir_opc),
        .flag_z  (flag_zero),
        .flag_n  (flag_neg),
        .ctl     (ctl),
        .state_q (state_q),
        .halted  (halted)
    );

    acc_cpu_dpath #(.ADDR_W(ADDR_W)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ir_opc    (ir_opc),
        .ir_addr   (ir_addr),
        .pc_q      (pc_q),
        .acc_q     (acc_value),
        .z_q       (flag_zero),
        .n_q       (flag_neg)
    );

    assign mem_rd = ctl.mem_rd;
    assign mem_wr = ctl.mem_wr;

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R10

    AST_FETCH_PC: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_FETCH) |-> (mem_rd && (mem_addr == pc_q))); // R1

    AST_BR_SKIP: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_BR_SKIP) |=> (pc_q == $past(pc_q) + ADDR_W'(1))); // R7

    AST_BR_TAKE: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_BR_TAKE) |=> (pc_q == $past(ir_addr))); // R7

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_rd && !mem_wr && $stable(acc_value))); // R9

endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

    localparam logic [3:0] LOAD = 4'h0, STORE = 4'h1, ADD = 4'h2, SUB = 4'h3,
                           INC = 4'h4, DEC = 4'h5, SHL = 4'h6, ROR = 4'h7,
                           BR = 4'h8, BRZ = 4'h9, BRN = 4'hA, HALT = 4'hF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [15:0] acc_value;
    logic        flag_zero, flag_neg, halted;

    logic [15:0] mem [0:255];

    int checks = 0;
    int errors = 0;
    int cyc, wr_cnt, rw_bad;

    always #10 clk = ~clk;

    acc_cpu u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .acc_value (acc_value),
        .flag_zero (flag_zero),
        .flag_neg  (flag_neg),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = ins(HALT, 12'h000);
    endtask

    task automatic run_prog();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cyc = 0; wr_cnt = 0; rw_bad = 0;
        while (!halted && cyc < 3000) begin
            if (mem_rd && mem_wr) rw_bad++;
            if (mem_wr) wr_cnt++;
            cyc++;
            @(negedge clk);
        end
        chk("R9", "halted reached", {31'd0, halted}, 32'd1);
        chk("R10", "rd/wr overlap cycles", rw_bad, 0);
    endtask

    task automatic test_reset();
        clear_mem();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "acc in reset", acc_value, 16'h0000);
        chk("R1", "flags in reset", {flag_zero, flag_neg}, 2'b00);
        chk("R1", "halted in reset", halted, 1'b0);
        chk("R1", "strobes in reset", {mem_rd, mem_wr}, 2'b00);
        rst = 1'b0;
        chk("R1", "no read in init", mem_rd, 1'b0);
        @(negedge clk);
        chk("R1", "first fetch rd", mem_rd, 1'b1);
        chk("R1", "first fetch addr", mem_addr, 12'h000);
        repeat (6) @(negedge clk);
        chk("R9", "halt-only program halts", halted, 1'b1);
    endtask

    task automatic test_arith();
        clear_mem();
        mem[0] = ins(LOAD, 12'h080);
        mem[1] = ins(ADD, 12'h081);
        mem[2] = ins(SUB, 12'h082);
        mem[3] = ins(STORE, 12'h083);
        mem[4] = ins(HALT, 12'h000);
        mem[8'h80] = 16'd5; mem[8'h81] = 16'd7; mem[8'h82] = 16'd20;
        mem[8'h83] = 16'h1234;
        run_prog();
        chk("R3", "acc after 5+7-20", acc_value, 16'hFFF8);
        chk("R4", "stored word", mem[8'h83], 16'hFFF8);
        chk("R4", "write strobe count", wr_cnt, 1);
        chk("R6", "flags kept across store", {flag_zero, flag_neg}, 2'b01);
        chk("R2", "cycles arith program", cyc, 23);
    endtask

    task automatic test_unary_shift();
        clear_mem();
        mem[0] = ins(LOAD, 12'h080);
        mem[1] = ins(SHL, 12'h000);
        mem[2] = ins(ROR, 12'h000);
        mem[3] = ins(DEC, 12'h000);
        mem[4] = ins(HALT, 12'h000);
        mem[8'h80] = 16'h8001;
        run_prog();
        chk("R5", "acc after shl/ror/dec", acc_value, 16'h0000);
        chk("R6", "zero flag set", {flag_zero, flag_neg}, 2'b10);
        chk("R5", "cycles unary program", cyc, 21);
        chk("R5", "no writes", wr_cnt, 0);
    endtask

    task automatic test_unary_wrap();
        clear_mem();
        mem[0] = ins(LOAD, 12'h080);
        mem[1] = ins(INC, 12'h000);
        mem[2] = ins(INC, 12'h000);
        mem[3] = ins(ROR, 12'h000);
        mem[4] = ins(HALT, 12'h000);
        mem[8'h80] = 16'hFFFF;
        run_prog();
        chk("R5", "acc after wrap and rotate", acc_value, 16'h8000);
        chk("R6", "negative flag set", {flag_zero, flag_neg}, 2'b01);
        chk("R5", "cycles wrap program", cyc, 21);
    endtask

    task automatic test_branch_a();
        clear_mem();
        mem[0] = ins(LOAD, 12'h080);
        mem[1] = ins(BRZ, 12'h004);
        mem[2] = ins(LOAD, 12'h081);
        mem[3] = ins(HALT, 12'h000);
        mem[4] = ins(BRN, 12'h007);
        mem[5] = ins(INC, 12'h000);
        mem[6] = ins(BR, 12'h008);
        mem[7] = ins(LOAD, 12'h081);
        mem[8] = ins(HALT, 12'h000);
        mem[8'h80] = 16'h0000; mem[8'h81] = 16'h1111;
        run_prog();
        chk("R7", "acc after brz taken, brn skipped, br", acc_value, 16'h0001);
        chk("R7", "cycles branch program A", cyc, 25);
    endtask

    task automatic test_branch_b();
        clear_mem();
        mem[0] = ins(LOAD, 12'h080);
        mem[1] = ins(BRZ, 12'h005);
        mem[2] = ins(BRN, 12'h004);
        mem[3] = ins(INC, 12'h000);
        mem[4] = ins(HALT, 12'h000);
        mem[5] = ins(DEC, 12'h000);
        mem[8'h80] = 16'h8000;
        run_prog();
        chk("R7", "acc after brz skipped, brn taken", acc_value, 16'h8000);
        chk("R6", "flags kept across branches", {flag_zero, flag_neg}, 2'b01);
        chk("R7", "cycles branch program B", cyc, 17);
    endtask

    task automatic test_nop();
        clear_mem();
        mem[0] = ins(LOAD, 12'h080);
        mem[1] = ins(4'hB, 12'h0A0);
        mem[2] = ins(4'hE, 12'h0A0);
        mem[3] = ins(HALT, 12'h000);
        mem[8'h80] = 16'h8003;
        mem[8'hA0] = 16'h5A5A;
        run_prog();
        chk("R8", "acc kept over no-ops", acc_value, 16'h8003);
        chk("R8", "flags kept over no-ops", {flag_zero, flag_neg}, 2'b01);
        chk("R8", "memory untouched", mem[8'hA0], 16'h5A5A);
        chk("R8", "no writes", wr_cnt, 0);
        chk("R8", "cycles no-op program", cyc, 15);
    endtask

    task automatic test_halt_hold();
        int strobes;
        int moved;
        clear_mem();
        mem[0] = ins(LOAD, 12'h080);
        mem[1] = ins(HALT, 12'h000);
        mem[2] = ins(INC, 12'h000);
        mem[8'h80] = 16'h0042;
        run_prog();
        strobes = 0; moved = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_rd || mem_wr) strobes++;
            if (!halted || acc_value !== 16'h0042) moved++;
        end
        chk("R9", "strobes while halted", strobes, 0);
        chk("R9", "halt/acc changes while halted", moved, 0);
        chk("R9", "cycles to halt", cyc, 9);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        test_reset();
        test_arith();
        test_unary_shift();
        test_unary_wrap();
        test_branch_a();
        test_branch_b();
        test_nop();
        test_halt_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule